// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block supervises software with a 16-bit up-counter. The counter advances on a tick from one of two count sources and expires after a power-of-two number of ticks chosen from four lengths. In watchdog mode an expiry either requests a system reset or raises a non-maskable interrupt. In interval mode the same counter acts as a free-running periodic timer: it raises an interrupt on each expiry and never resets anything.

Every control write has to carry a fixed key in its upper byte. A write with any other upper byte is thrown away and counts as a key violation. The violation then triggers a reset request, or a non-maskable interrupt if configuration asks for that. Reads return a different constant in the upper byte, so code that reads the register, modifies it and writes it back does not present a valid key. A sticky status word records why the last watchdog reset happened and whether a non-resetting expiry has occurred. The block's own registers are cleared only by `rstN`. A reset request from the block returns the control register to its default, and the status flags survive it.

Top module: `keyed_wdog`

## Requirements
- R1: After `rstN` the control read is 16'h6900: hold off, watchdog mode with reset action, source A, period code 2'b00. The status read is 16'h6900 and no request output is high.
- R2: Both reads return 8'h69 in bits [15:8]. The control read places hold in bit 7, NMI select in bit 6, interval mode in bit 5, key-violation NMI select in bit 3, source select in bit 2 and period code in bits [1:0]. Bit 4 and bits other than those named read 0.
- R3: A write with 8'h5A in bits [15:8] loads those control fields. If bit 4 of the same write is 1, the counter restarts from zero.
- R4: A write with any other upper byte leaves the written fields unapplied and sets status bit 1 (key violation) while clearing status bit 0. With bit 3 clear, `sysRstReq` pulses in the next cycle and the control register returns to 16'h6900. With bit 3 set, `nmiReq` pulses instead and the control register is kept.
- R5: Period codes 2'b00, 2'b01, 2'b10 and 2'b11 give expiry after exactly 2^15, 2^13, 2^9 and 2^6 ticks of the selected source, counted from a clearing write.
- R6: Source select 0 counts `tickA` and source select 1 counts `tickB`.
- R7: In watchdog mode with NMI select 0, an expiry pulses `sysRstReq`, sets status bit 0, clears status bit 1 and returns the control register to 16'h6900.
- R8: In watchdog mode with NMI select 1, an expiry pulses `nmiReq`, keeps the control register, sets status bit 2, and counting continues with the same period.
- R9: In interval mode an expiry pulses `intIrq` periodically and sets status bit 2, whatever the NMI select bit holds. `sysRstReq` stays low.
- R10: While hold is 1 the counter does not advance and nothing expires. After a keyed write clears hold without bit 4, counting resumes from the held value.
- R11: A keyed write clears all three status flags. A keyed write with bit 4 at 0 does not restart the counter.
- R12: At most one of `sysRstReq`, `nmiReq` and `intIrq` is high in a cycle, and an expiry pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rstN | input | 1 | Active-low reset of all block state |
| tickA | input | 1 | Count enable from source A |
| tickB | input | 1 | Count enable from source B |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | 16 | Write data, key in [15:8] |
| rdSel | input | 1 | Read select: 0 control, 1 status |
| rdData | output | 16 | Read data, tag 8'h69 in [15:8] |
| sysRstReq | output | 1 | One-cycle system reset request |
| nmiReq | output | 1 | One-cycle non-maskable interrupt request |
| intIrq | output | 1 | One-cycle interval timer interrupt |

## Verification
A wrong counter value shows up as an expiry pulse that is early or late by an exact number of source ticks. It therefore becomes visible only at the next expiry, up to 2^15 ticks later, and the bench measures each period in ticks rather than in cycles. A mishandled key check appears on the cycle after the write, either as a missing or wrong request pulse or as a changed control read. A flag that is stuck or cleared at the wrong time is visible at once on the status read.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  // control byte positions; software-visible, so fixed
  localparam int HOLD_BIT  = 7;
  localparam int NMI_BIT   = 6;
  localparam int IVL_BIT   = 5;
  localparam int CLR_BIT   = 4;
  localparam int KVNMI_BIT = 3;
  localparam int SRC_BIT   = 2;

  typedef struct packed {
    logic       hold;
    logic       nmiSel;
    logic       ivMode;
    logic       kvNmi;
    logic       srcSel;
    logic [1:0] tapSel;
  } wdogCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       clrCnt;
    logic       runEn;
    logic       srcSel;
    logic [1:0] tapSel;
  } wdogStrb_t;
endpackage

// File: rtl/wdog_dp.sv
`timescale 1ns/1ps
module wdog_dp #(
  parameter int CNT_W    = 16,
  parameter int TAP_SLOW = 15,
  parameter int TAP_MID  = 13,
  parameter int TAP_LOW  = 9,
  parameter int TAP_FAST = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickA,
  input  logic                tickB,
  input  wdog_pkg::wdogStrb_t strb,
  output logic                hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             adv;

  assign adv = (strb.srcSel ? tickB : tickA) && strb.runEn;

  always_comb begin
    case (strb.tapSel)
      2'b00:   lim = (ONE << TAP_SLOW) - ONE;
      2'b01:   lim = (ONE << TAP_MID)  - ONE;
      2'b10:   lim = (ONE << TAP_LOW)  - ONE;
      default: lim = (ONE << TAP_FAST) - ONE;
    endcase
  end

  assign hit = adv && (cnt == lim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (strb.clrCnt) cnt <= '0;
    else if (hit)         cnt <= '0;
    else if (adv)         cnt <= cnt + ONE;
  end
endmodule

// File: rtl/wdog_ctrl.sv
`timescale 1ns/1ps
module wdog_ctrl #(
  parameter logic [7:0] KEY      = 8'h5A,
  parameter logic [7:0] READ_TAG = 8'h69
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [15:0]         wrData,
  input  logic                rdSel,
  input  logic                hit,
  output wdog_pkg::wdogStrb_t strb,
  output logic [15:0]         rdData,
  output logic                sysRstReq,
  output logic                nmiReq,
  output logic                intIrq
);
  import wdog_pkg::*;

  wdogCfg_t cfg;
  logic     keyOk, keyBad, wantClr, expire, wdRst, kvRst;
  logic     toFlag, kvFlag, expFlag;

  assign keyOk   = wrEn && (wrData[15:8] == KEY);
  assign keyBad  = wrEn && !keyOk;
  assign wantClr = keyOk && wrData[CLR_BIT];
  assign expire  = hit && !keyBad && !wantClr;
  assign wdRst   = expire && !cfg.ivMode && !cfg.nmiSel;
  assign kvRst   = keyBad && !cfg.kvNmi;

  assign strb.clrCnt = keyBad || wantClr || wdRst;
  assign strb.runEn  = !cfg.hold;
  assign strb.srcSel = cfg.srcSel;
  assign strb.tapSel = cfg.tapSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg       <= '0;
      sysRstReq <= 1'b0;
      nmiReq    <= 1'b0;
      intIrq    <= 1'b0;
      toFlag    <= 1'b0;
      kvFlag    <= 1'b0;
      expFlag   <= 1'b0;
    end else begin
      sysRstReq <= kvRst || wdRst;
      nmiReq    <= (keyBad && cfg.kvNmi) ||
                   (expire && !cfg.ivMode && cfg.nmiSel);
      intIrq    <= expire && cfg.ivMode;

      if (kvRst || wdRst) begin
        cfg <= '0;
      end else if (keyOk) begin
        cfg.hold   <= wrData[HOLD_BIT];
        cfg.nmiSel <= wrData[NMI_BIT];
        cfg.ivMode <= wrData[IVL_BIT];
        cfg.kvNmi  <= wrData[KVNMI_BIT];
        cfg.srcSel <= wrData[SRC_BIT];
        cfg.tapSel <= wrData[1:0];
      end

      if (keyBad) begin
        kvFlag <= 1'b1;
        toFlag <= 1'b0;
      end else if (wdRst) begin
        toFlag <= 1'b1;
        kvFlag <= 1'b0;
      end else if (keyOk) begin
        toFlag  <= 1'b0;
        kvFlag  <= 1'b0;
        expFlag <= 1'b0;
      end else if (expire) begin
        expFlag <= 1'b1;
      end
    end
  end

  always_comb begin
    if (rdSel)
      rdData = {READ_TAG, 5'b0, expFlag, kvFlag, toFlag};
    else
      rdData = {READ_TAG, cfg.hold, cfg.nmiSel, cfg.ivMode, 1'b0,
                cfg.kvNmi, cfg.srcSel, cfg.tapSel};
  end
endmodule

// File: rtl/keyed_wdog.sv
`timescale 1ns/1ps
module keyed_wdog #(
  parameter int         CNT_W    = 16,
  parameter int         TAP_SLOW = 15,
  parameter int         TAP_MID  = 13,
  parameter int         TAP_LOW  = 9,
  parameter int         TAP_FAST = 6,
  parameter logic [7:0] KEY      = 8'h5A,
  parameter logic [7:0] READ_TAG = 8'h69
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickA,
  input  logic        tickB,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  input  logic        rdSel,
  output logic [15:0] rdData,
  output logic        sysRstReq,
  output logic        nmiReq,
  output logic        intIrq
);
  wdog_pkg::wdogStrb_t strb;
  logic                hit;

  wdog_ctrl #(.KEY(KEY), .READ_TAG(READ_TAG)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdSel(rdSel),
    .hit(hit), .strb(strb), .rdData(rdData), .sysRstReq(sysRstReq),
    .nmiReq(nmiReq), .intIrq(intIrq)
  );

  wdog_dp #(.CNT_W(CNT_W), .TAP_SLOW(TAP_SLOW), .TAP_MID(TAP_MID),
            .TAP_LOW(TAP_LOW), .TAP_FAST(TAP_FAST)) u_dp (
    .clk(clk), .rstN(rstN), .tickA(tickA), .tickB(tickB),
    .strb(strb), .hit(hit)
  );
endmodule

// File: rtl/wdog_chk.sv
`timescale 1ns/1ps
module wdog_chk #(
  parameter logic [7:0] KEY = 8'h5A
) (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrKey,
  input logic       wrClr,
  input logic       rdSel,
  input logic       rdExp,
  input logic       runEn,
  input logic       sysRstReq,
  input logic       nmiReq,
  input logic       intIrq
);
  // R4
  kv_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (wrKey != KEY) |=> sysRstReq || nmiReq);

  // R12
  one_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sysRstReq, nmiReq, intIrq}));

  // R12
  irq_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    intIrq |=> !intIrq);

  // R10
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn && !wrEn |=> !sysRstReq && !nmiReq && !intIrq);

  // R3
  clr_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (wrKey == KEY) && wrClr |=> !sysRstReq && !nmiReq && !intIrq);

  // R9
  exp_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    intIrq && rdSel && !$past(wrEn) |-> rdExp);
endmodule

bind keyed_wdog wdog_chk #(.KEY(KEY)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrKey(wrData[15:8]),
  .wrClr(wrData[4]), .rdSel(rdSel), .rdExp(rdData[2]),
  .runEn(strb.runEn), .sysRstReq(sysRstReq), .nmiReq(nmiReq),
  .intIrq(intIrq)
);

// File: tb/keyed_wdog_tb.sv
`timescale 1ns/1ps
module keyed_wdog_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickA = 1'b1;
  logic        tickB = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdSel = 1'b0;
  logic [15:0] rdData;
  logic        sysRstReq, nmiReq, intIrq;

  int checks = 0;
  int fails  = 0;

  keyed_wdog u_dut (
    .clk(clk), .rstN(rstN), .tickA(tickA), .tickB(tickB), .wrEn(wrEn),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData),
    .sysRstReq(sysRstReq), .nmiReq(nmiReq), .intIrq(intIrq)
  );

  always #2.5 clk = ~clk;
  always @(negedge clk) tickB <= ~tickB;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    wrEn = 1'b1; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    rdSel = sel; #0.5; v = rdData;
  endtask

  // which: 0 sysRstReq, 1 nmiReq, 2 intIrq; counts ticks of chosen source
  task automatic measure(input int which, input bit useB, output int n,
                         output int stray);
    bit done = 0;
    int edges = 0;
    logic [2:0] p;
    n = 0; stray = 0;
    while (!done && edges < 80000) begin
      @(posedge clk);
      edges++;
      if (useB ? tickB : tickA) n++;
      @(negedge clk);
      p = {intIrq, nmiReq, sysRstReq};
      if (p[which]) done = 1;
      if ((p & ~(3'b1 << which)) != 3'b0) stray++;
    end
  endtask

  task automatic idle(input int k, output int seen);
    seen = 0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (sysRstReq || nmiReq || intIrq) seen++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n, stray, seen;
    int expo[4] = '{15, 13, 9, 6};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); check("R1 ctrl", v, 16'h6900);
    rd(1, v); check("R1 status", v, 16'h6900);
    check("R1 no requests", {sysRstReq, nmiReq, intIrq}, 0);

    // R5 R6 R9 interval periods, source A, all codes
    for (int t = 0; t < 4; t++) begin
      wr(16'h5A30 | 16'(t));
      measure(2, 0, n, stray);
      check("R5 period srcA", n, 1 << expo[t]);
      check("R9 no reset in interval", stray, 0);
      @(negedge clk);
      check("R12 pulse width", intIrq, 0);
    end
    // R6 source B, shorter codes
    for (int t = 1; t < 4; t++) begin
      wr(16'h5A34 | 16'(t));
      measure(2, 1, n, stray);
      check("R6 period srcB", n, 1 << expo[t]);
    end
    // R9 interval ignores NMI select; R2 read fields
    wr(16'h5A73);
    rd(0, v); check("R2 ctrl readback", v, 16'h6963);
    measure(2, 0, n, stray);
    check("R9 interval with nmi sel", n, 64);
    check("R9 stray", stray, 0);
    rd(1, v); check("R9 exp flag", v, 16'h6904);
    measure(2, 0, n, stray);
    check("R9 periodic", n, 64);

    // R11 keyed write clears flags, no-clear write keeps count
    wr(16'h5A33);
    rd(1, v); check("R11 flags cleared", v, 16'h6900);
    for (int i = 0; i < 30; i++) @(negedge clk);
    wr(16'h5A23);
    measure(2, 0, n, stray);
    check("R11 no restart", n, 33);

    // R10 hold
    wr(16'h5A33);
    for (int i = 0; i < 20; i++) @(negedge clk);
    wr(16'h5AA3);
    idle(200, seen);
    check("R10 held quiet", seen, 0);
    wr(16'h5A23);
    measure(2, 0, n, stray);
    check("R10 resume", n, 43);

    // R8 NMI action
    wr(16'h5A53);
    rd(0, v); check("R2 clr reads zero", v, 16'h6943);
    measure(1, 0, n, stray);
    check("R8 nmi period", n, 64);
    check("R8 no reset", stray, 0);
    rd(0, v); check("R8 ctrl kept", v, 16'h6943);
    rd(1, v); check("R8 exp flag", v, 16'h6904);
    measure(1, 0, n, stray);
    check("R8 periodic", n, 64);

    // R7 reset action
    wr(16'h5A13);
    measure(0, 0, n, stray);
    check("R7 reset period", n, 64);
    rd(0, v); check("R7 ctrl default", v, 16'h6900);
    rd(1, v); check("R7 timeout flag", v, 16'h6901);

    // R4 wrong key, reset action
    wr(16'h5A33);
    wr(16'hA533);
    check("R4 reset pulse", {sysRstReq, nmiReq}, 2'b10);
    rd(0, v); check("R4 ctrl discarded", v, 16'h6900);
    rd(1, v); check("R4 kv flag", v, 16'h6902);
    @(negedge clk);
    check("R12 single pulse", sysRstReq, 0);
    // R4 readback tag is not a key
    rd(0, v);
    wr(v | 16'h0013);
    check("R4 replay rejected", sysRstReq, 1);
    // R4 wrong key, NMI action
    wr(16'h5A18);
    wr(16'h1100);
    check("R4 nmi pulse", {sysRstReq, nmiReq}, 2'b01);
    rd(0, v); check("R4 ctrl kept", v, 16'h6908);
    rd(1, v); check("R4 kv flag nmi", v, 16'h6902);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule